// File: doc/BRIEF.md
# CAN Interrupt Pending Flags and Priority Coder

This block keeps the interrupt pending state of one CAN node: a single error flag and fifteen message-buffer flags. Each flag is set by a one-cycle event pulse from the protocol engine. Software clears a flag by writing a one to its bit in a write-one-to-clear register.

A code-enable mask selects which pending flags take part in a priority search. The mask only affects the search: a masked flag still stays pending. The winning source is reported as a request bit and a 4-bit code. These sit in a status word together with a 3-bit node status supplied from outside. The request bit also drives a single interrupt output.

Software reaches the block through a small register port with a 2-bit address. Address 0 is the status word and is read-only. Address 1 is the code-enable mask, which can be read and written. Address 2 is the clear register, which is write-only. Address 3 is the pending-flag image and is read-only. Writes to addresses 0 and 3 have no effect.

Top module: `can_irq_coder`

## Requirements
- R1: After reset every pending flag and every enable bit is 0, the status word reads 0x0000 (with node status 000) and `irq` is 0.
- R2: A high pulse on `evt_err` or on `evt_buf[n]` sets that pending flag at the next clock edge. Address 3 reads the flags with the error flag at bit 15 and buffer n at bit n.
- R3: A write to address 2 clears each pending flag whose data bit is 1 (bit 15 is error, bit n is buffer n). Flags whose data bit is 0 are unchanged. Address 2 always reads as 0x0000.
- R4: If an event pulse and a write-one clear hit the same flag in the same cycle, the flag is set afterwards.
- R5: Address 1 is a read/write enable mask: bit 15 enables the error source and bit n enables buffer n.
- R6: A pending flag whose enable bit is 0 is left out of the code, but it stays pending at address 3.
- R7: When no pending flag is also enabled, the request bit is 0 and the code is 0000.
- R8: A pending, enabled error flag gives request 1 and code 0000, whatever buffers are pending.
- R9: Otherwise, the lowest-numbered pending, enabled buffer n gives request 1 and code n+1 (buffer 14 gives 1111).
- R10: The status word at address 0 holds the code in bits 3:0, the request in bit 4 and `node_state` in bits 7:5. Bits 15:8 read 0. The node status encodings pass through unchanged: 000 not active, 010 error active, 011 error warning, 10x error passive, 11x bus off.
- R11: `irq` equals the request bit at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_err | input | 1 | Error interrupt event pulse |
| evt_buf | input | 15 | Per-buffer interrupt event pulses |
| node_state | input | 3 | Node status from the protocol engine |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data (combinational on addr) |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following: a write-one clear actually empties its flags, an event always leaves its flag set, an enabled error gets code 0000, an idle request carries a zero code, the reserved status bits stay zero, and `irq` tracks the request bit. The bench scenarios are needed to show the rest. That covers lowest-buffer-wins ordering across many flag patterns, masked flags surviving at address 3, and enable read-back. It also covers same-cycle set/clear collisions and the pass-through of every node status encoding. The reference model and the design are compared on every clock.

// File: rtl/can_irq_coder.sv
module can_irq_coder #(
  parameter int NBUF = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_err,
  input  logic [NBUF-1:0] evt_buf,
  input  logic [2:0]      node_state,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [NBUF:0]   wdata,
  output logic [NBUF:0]   rdata,
  output logic            irq
);
  localparam int W  = NBUF + 1;
  localparam int CW = $clog2(NBUF + 1);

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_CLR  = 2'd2;
  localparam logic [1:0] A_PEND = 2'd3;

  logic [W-1:0]  pend, en, hit, clr, evt;
  logic [CW-1:0] code;
  logic          req;
  logic [W-1:0]  status;

  assign evt = {evt_err, evt_buf};
  assign clr = (wr_en && addr == A_CLR) ? wdata : '0;
  assign hit = pend & en;
  assign req = |hit;
  assign irq = req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= (pend & ~clr) | evt;
      if (wr_en && addr == A_EN) en <= wdata;
    end
  end

  always_comb begin
    code = '0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (hit[i]) code = CW'(i + 1);
    if (hit[NBUF]) code = '0;
  end

  always_comb begin
    status = '0;
    status[CW-1:0]     = code;
    status[CW]         = req;
    status[CW+3:CW+1]  = node_state;
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = status;
      A_EN:    rdata = en;
      A_PEND:  rdata = pend;
      default: rdata = '0;
    endcase
  end

  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((pend & $past(clr & ~evt)) == '0));

  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

  a_r7_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !status[CW] |-> (status[CW-1:0] == '0));

  a_r8_error_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[NBUF] && en[NBUF]) |-> (status[CW] && status[CW-1:0] == '0));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[W-1:CW+4] == '0));

  a_r11_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq == status[CW]);
endmodule

// File: tb/can_irq_coder_test.sv
`timescale 1ns/1ps
module can_irq_coder_test;
  logic        clk = 0, rst_n = 0, evt_err = 0, wr_en = 0;
  logic [14:0] evt_buf = '0;
  logic [2:0]  node_state = '0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;

  int compared = 0, mismatched = 0;
  bit m_pend[16];
  bit m_en[16];
  string tag = "R1";

  can_irq_coder uut (.clk, .rst_n, .evt_err, .evt_buf, .node_state,
                     .wr_en, .addr, .wdata, .rdata, .irq);

  always #10 clk = ~clk;

  function automatic int exp_code(output bit rq);
    rq = 0;
    if (m_pend[15] && m_en[15]) begin rq = 1; return 0; end
    for (int n = 0; n < 15; n++)
      if (m_pend[n] && m_en[n]) begin rq = 1; return n + 1; end
    return 0;
  endfunction

  function automatic logic [15:0] exp_rd(int a);
    int v = 0;
    bit rq;
    int c;
    case (a)
      0: begin
        c = exp_code(rq);
        v = c + (rq ? 16 : 0) + 32 * int'(node_state);
      end
      1: for (int b = 0; b < 16; b++) if (m_en[b]) v += (1 << b);
      3: for (int b = 0; b < 16; b++) if (m_pend[b]) v += (1 << b);
      default: v = 0;
    endcase
    return v[15:0];
  endfunction

  task automatic compare();
    bit rq;
    int c;
    logic [15:0] e;
    c = exp_code(rq);
    e = exp_rd(int'(addr));
    compared++;
    if (rdata !== e) begin
      mismatched++;
      $display("FAIL %s: rdata at addr %0d = %h, expected %h", tag, addr, rdata, e);
    end
    compared++;
    if (irq !== rq) begin
      mismatched++;
      $display("FAIL %s: irq = %b, expected %b (R11)", tag, irq, rq);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      for (int b = 0; b < 16; b++) begin m_pend[b] = 0; m_en[b] = 0; end
    end else begin
      for (int b = 0; b < 16; b++) begin
        bit ev = (b == 15) ? evt_err : evt_buf[b];
        if (wr_en && addr == 2 && wdata[b]) m_pend[b] = 0;
        if (ev) m_pend[b] = 1;
      end
      if (wr_en && addr == 1)
        for (int b = 0; b < 16; b++) m_en[b] = wdata[b];
    end
    @(negedge clk);
    compare();
    evt_err = 0; evt_buf = '0; wr_en = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1; step();
  endtask

  task automatic rd(logic [1:0] a);
    addr = a; step();
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tag = "R1";
    step(); step();
    rst_n = 1;
    rd(0); rd(1); rd(3);

    tag = "R2";
    evt_buf = 15'h0010; evt_err = 1; rd(3);
    rd(0);
    tag = "R6";
    rd(3);

    tag = "R5";
    wr(1, 16'h0010); rd(1); rd(0);
    tag = "R9";
    evt_buf = 15'h4000; rd(0);
    wr(1, 16'h4010); rd(0);
    wr(2, 16'h0010); rd(0);
    tag = "R8";
    wr(1, 16'hFFFF); rd(0);
    tag = "R3";
    wr(2, 16'h8000); rd(0); rd(3); rd(2);
    wr(2, 16'h0000); rd(3);
    tag = "R4";
    evt_buf = 15'h0001; addr = 2; wdata = 16'hFFFF; wr_en = 1; step();
    rd(3); rd(0);
    tag = "R7";
    wr(2, 16'hFFFF); rd(0);
    evt_buf = 15'h0003; rd(0);
    wr(1, 16'h0000); rd(0); rd(3);

    tag = "R10";
    wr(1, 16'hFFFF);
    for (int s = 0; s < 8; s++) begin node_state = s[2:0]; rd(0); end
    wr(0, 16'hFFFF); rd(0);
    wr(3, 16'h0000); rd(3);

    tag = "R9";
    for (int n = 0; n < 15; n++) begin
      wr(2, 16'hFFFF);
      evt_buf = 15'((15'h7FFF << n)); rd(0);
    end

    tag = "R11";
    for (int k = 0; k < 3000; k++) begin
      evt_err = ($urandom_range(0, 15) == 0);
      evt_buf = 15'($urandom) & 15'($urandom) & 15'($urandom);
      node_state = 3'($urandom);
      addr = 2'($urandom);
      wr_en = ($urandom_range(0, 3) == 0);
      wdata = 16'($urandom);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule